// File: doc/BRIEF.md
# Tuner Synthesizer Serial Register Interface

This block is the receive side of a three-line serial link that programs a radio tuning synthesizer. A host drives an enable line, a serial clock and a data line. While the enable line is high, each falling edge of the serial clock moves one data bit into a shift register, most significant bit first. When the enable line drops, the block keeps the word only if exactly eight bits were clocked in. The top two bits of a kept word select one of four buffer registers, and the low six bits are written there. Words of any other length are thrown away.

The buffer registers hold the control fields: test bits, the output flag, the charge-pump current code, the reference-step select, the loop-filter input select, the swallow/direct mode and the AM/FM band. They also hold the two counter ratios. The eight-bit programmable ratio arrives in two parts. Those parts are held in a staging register and reach the ratio output only when a swallow-count word arrives, so the divider never sees a half-updated value. All three serial lines are synchronised into the system clock domain, so the serial rate must be well below the system clock rate.

Top module: `tuner_serial_regs`

## Requirements
- R1: While reset is active, and on the first cycle after it, every field output and both ratio outputs are zero, `out_flag` is 0 and `standby` is 1.
- R2: Bits are taken on falling edges of `ser_clk` while `ser_en` is high, and the first bit taken becomes word bit 7. Falling edges of `ser_clk` while `ser_en` is low have no effect.
- R3: A word with address bits [7:6] = 00 sets `test_bits` from bits [5:3], the output-flag register from bit 2, `pump_sel[0]` from bit 1 and `ref_sel` from bit 0.
- R4: A word with address 01 sets staged ratio bits [7:6] from word bits [5:4], `lpf_sel` from bit 3, `pump_sel[1]` from bit 2, `swallow_mode` from bit 1 and `am_band` from bit 0.
- R5: A word with address 10 sets staged ratio bits [5:0] from word bits [5:0] and leaves `prog_ratio` unchanged.
- R6: A word with address 11 sets `swallow_cnt` from bits [5:0] and copies the whole staged ratio to `prog_ratio`. `prog_ratio` changes at no other time.
- R7: A word closed by the fall of `ser_en` after any number of `ser_clk` falls other than eight changes no output.
- R8: Words may arrive in any order and be repeated. Each register keeps the value from the last valid word that addressed it.
- R9: `standby` drops with the first address-11 word after reset and stays low until the next reset.
- R10: `out_flag` is 1 (released high) when the output-flag register is 1, and 0 (pulled low) when it is 0.
- R11: A valid word's outputs appear on the third rising edge of `clk` after `ser_en` falls. After two edges the old values are still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| ser_clk | input | 1 | Serial bit clock, data taken on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Word framing enable, high during a word |
| test_bits | output | 3 | Test field |
| out_flag | output | 1 | Open-drain style flag, 1 = released, 0 = pulled low |
| pump_sel | output | 2 | Charge-pump current code |
| ref_sel | output | 1 | Reference step select |
| lpf_sel | output | 1 | Loop-filter input select |
| swallow_mode | output | 1 | 1 = swallow mode, 0 = direct mode |
| am_band | output | 1 | 1 = AM, 0 = FM |
| prog_ratio | output | 8 | Committed programmable counter ratio |
| swallow_cnt | output | 6 | Swallow counter value |
| standby | output | 1 | Standby active |

## Verification
Every result follows the fall of `ser_en` by a fixed delay of three rising edges of `clk`: two synchroniser stages and one register write. The bench drives all inputs on falling edges of `clk`. In the latency scenario it samples on the falling edge after the second rising edge, expecting old values, and again after the third, expecting new values. The other scenarios wait six cycles after each word before sampling. This keeps every check clear of the update edge. The serial clock half-period is four system cycles, so each data bit passes the synchroniser before the serial clock falls.

// File: rtl/tuner_serial_pkg.sv
// Shared constants and address codes for the tuner serial register interface.
// Assumes a fixed word of 8 bits: 2 address bits above 6 data bits.
package tuner_serial_pkg;
    localparam int WORD_BITS  = 8;
    localparam int ADDR_BITS  = 2;
    localparam int DATA_BITS  = WORD_BITS - ADDR_BITS;
    localparam int RATIO_BITS = 8;
    localparam int SWC_BITS   = DATA_BITS;
    localparam int TEST_BITS  = 3;
    localparam int CNT_BITS   = $clog2(WORD_BITS + 2);

    typedef enum logic [ADDR_BITS-1:0] {
        WA_CTRL   = 2'b00,
        WA_CTRLHI = 2'b01,
        WA_RATLO  = 2'b10,
        WA_SWALLOW = 2'b11
    } word_addr_e;
endpackage

// File: rtl/serial_line_sync.sv
// Synchroniser and edge detector for a group of slow asynchronous lines.
// Assumes STAGES >= 2 and that each line stays put for more than STAGES+1 clocks.
module serial_line_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pins,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Move the pin through the synchroniser chain and keep the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pins[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign level[g] = chain[STAGES-1];
        assign rise[g]  = chain[STAGES-1] & ~last;
        assign fall[g]  = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/serial_word_capture.sv
// Shifts in serial bits MSB first and counts them. At the end of a frame it
// flags the word as good only when exactly WORD_BITS bits were taken.
// Assumes synchronised, edge-detected inputs from serial_line_sync.
module serial_word_capture
    import tuner_serial_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_level,
    input  logic                 en_rise,
    input  logic                 en_fall,
    input  logic                 sclk_fall,
    input  logic                 sdata,
    output logic                 word_ok,
    output logic [WORD_BITS-1:0] word,
    output logic [CNT_BITS-1:0]  bit_cnt
);
    localparam logic [CNT_BITS-1:0] CNT_FULL = CNT_BITS'(WORD_BITS);
    localparam logic [CNT_BITS-1:0] CNT_SAT  = CNT_BITS'(WORD_BITS + 1);

    logic [WORD_BITS-1:0] shreg;

    // Restart the count at frame start, and shift plus count on each bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (en_rise) begin
            bit_cnt <= '0;
        end else if (en_level && sclk_fall) begin
            shreg <= {shreg[WORD_BITS-2:0], sdata};
            if (bit_cnt != CNT_SAT)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign word    = shreg;
    assign word_ok = en_fall && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/tuner_reg_bank.sv
// Buffer registers written by valid words. The programmable ratio is staged
// and only committed when a swallow-count word arrives, which also ends standby.
// Assumes word_ok is a single-cycle strobe with word stable during it.
module tuner_reg_bank
    import tuner_serial_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_ok,
    input  logic [WORD_BITS-1:0]  word,
    output logic [TEST_BITS-1:0]  test_bits,
    output logic                  flag_reg,
    output logic [1:0]            pump_sel,
    output logic                  ref_sel,
    output logic                  lpf_sel,
    output logic                  swallow_mode,
    output logic                  am_band,
    output logic [RATIO_BITS-1:0] prog_ratio,
    output logic [SWC_BITS-1:0]   swallow_cnt,
    output logic                  standby
);
    logic [RATIO_BITS-1:0] ratio_stage;
    logic [DATA_BITS-1:0]  dat;
    word_addr_e            adr;

    assign adr = word_addr_e'(word[WORD_BITS-1 -: ADDR_BITS]);
    assign dat = word[DATA_BITS-1:0];

    // Write the addressed buffer register on a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_bits    <= '0;
            flag_reg     <= 1'b0;
            pump_sel     <= '0;
            ref_sel      <= 1'b0;
            lpf_sel      <= 1'b0;
            swallow_mode <= 1'b0;
            am_band      <= 1'b0;
            ratio_stage  <= '0;
            prog_ratio   <= '0;
            swallow_cnt  <= '0;
            standby      <= 1'b1;
        end else if (word_ok) begin
            case (adr)
                WA_CTRL: begin
                    test_bits   <= dat[5:3];
                    flag_reg    <= dat[2];
                    pump_sel[0] <= dat[1];
                    ref_sel     <= dat[0];
                end
                WA_CTRLHI: begin
                    ratio_stage[7:6] <= dat[5:4];
                    lpf_sel          <= dat[3];
                    pump_sel[1]      <= dat[2];
                    swallow_mode     <= dat[1];
                    am_band          <= dat[0];
                end
                WA_RATLO: begin
                    ratio_stage[5:0] <= dat[5:0];
                end
                default: begin
                    swallow_cnt <= dat;
                    prog_ratio  <= ratio_stage;
                    standby     <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tuner_serial_regs.sv
// Top of the three-line serial register interface: synchronises the lines,
// captures 8-bit words and writes them into the buffer register bank.
// Assumes the serial clock half-period exceeds SYNC_STAGES+2 system clocks.
module tuner_serial_regs
    import tuner_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_data,
    input  logic                  ser_en,
    output logic [TEST_BITS-1:0]  test_bits,
    output logic                  out_flag,
    output logic [1:0]            pump_sel,
    output logic                  ref_sel,
    output logic                  lpf_sel,
    output logic                  swallow_mode,
    output logic                  am_band,
    output logic [RATIO_BITS-1:0] prog_ratio,
    output logic [SWC_BITS-1:0]   swallow_cnt,
    output logic                  standby
);
    localparam int L_CLK = 0;
    localparam int L_DAT = 1;
    localparam int L_EN  = 2;

    logic [2:0]           lvl, rse, fll;
    logic                 word_ok;
    logic [WORD_BITS-1:0] word;
    logic [CNT_BITS-1:0]  bit_cnt;
    logic                 flag_reg;

    serial_line_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({ser_en, ser_data, ser_clk}),
        .level (lvl),
        .rise  (rse),
        .fall  (fll)
    );

    serial_word_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_level  (lvl[L_EN]),
        .en_rise   (rse[L_EN]),
        .en_fall   (fll[L_EN]),
        .sclk_fall (fll[L_CLK]),
        .sdata     (lvl[L_DAT]),
        .word_ok   (word_ok),
        .word      (word),
        .bit_cnt   (bit_cnt)
    );

    tuner_reg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_ok      (word_ok),
        .word         (word),
        .test_bits    (test_bits),
        .flag_reg     (flag_reg),
        .pump_sel     (pump_sel),
        .ref_sel      (ref_sel),
        .lpf_sel      (lpf_sel),
        .swallow_mode (swallow_mode),
        .am_band      (am_band),
        .prog_ratio   (prog_ratio),
        .swallow_cnt  (swallow_cnt),
        .standby      (standby)
    );

    assign out_flag = flag_reg;

    logic unused_rise;
    assign unused_rise = |{rse[L_CLK], rse[L_DAT], fll[L_DAT]};
endmodule

// File: rtl/tuner_serial_regs_chk.sv
// Property checker for tuner_serial_regs, attached with bind below.
module tuner_serial_regs_chk
    import tuner_serial_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  word_ok,
    input logic [WORD_BITS-1:0]  word,
    input logic [CNT_BITS-1:0]   bit_cnt,
    input logic [RATIO_BITS-1:0] prog_ratio,
    input logic                  standby,
    input logic [15:0]           ctrl_vec
);
    logic commit;
    assign commit = word_ok && (word[WORD_BITS-1 -: ADDR_BITS] == 2'b11);

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(prog_ratio));

    // R9
    standby_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |=> !standby);

    // R9
    commit_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !standby);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok |=> !word_ok);

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ok |=> $stable(ctrl_vec));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_BITS'(WORD_BITS + 1));
endmodule

bind tuner_serial_regs tuner_serial_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_ok    (word_ok),
    .word       (word),
    .bit_cnt    (bit_cnt),
    .prog_ratio (prog_ratio),
    .standby    (standby),
    .ctrl_vec   ({test_bits, out_flag, pump_sel, ref_sel, lpf_sel,
                  swallow_mode, am_band, swallow_cnt})
);

// File: tb/test_tuner_serial_regs.sv
// Directed bench for tuner_serial_regs: one task per scenario.
module test_tuner_serial_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_en = 1'b0;
    logic [2:0] test_bits;
    logic       out_flag;
    logic [1:0] pump_sel;
    logic       ref_sel, lpf_sel, swallow_mode, am_band;
    logic [7:0] prog_ratio;
    logic [5:0] swallow_cnt;
    logic       standby;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tuner_serial_regs i_tuner_serial_regs (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .test_bits(test_bits), .out_flag(out_flag),
        .pump_sel(pump_sel), .ref_sel(ref_sel), .lpf_sel(lpf_sel),
        .swallow_mode(swallow_mode), .am_band(am_band),
        .prog_ratio(prog_ratio), .swallow_cnt(swallow_cnt), .standby(standby)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Frame with n serial clock falls; bits beyond 8 are zero. Leaves ser_en high.
    task automatic frame_open(input logic [7:0] w, input int n);
        @(negedge clk);
        ser_en = 1'b1;
        wait_neg(4);
        for (int i = 0; i < n; i++) begin
            ser_data = (i < 8) ? w[7-i] : 1'b0;
            ser_clk  = 1'b1;
            wait_neg(4);
            ser_clk  = 1'b0;
            wait_neg(4);
        end
    endtask

    task automatic send(input logic [7:0] w, input int n);
        frame_open(w, n);
        ser_en = 1'b0;
        wait_neg(6);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ser_en = 1'b0; ser_clk = 1'b0; ser_data = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 test_bits", test_bits, 0);
        check("R1 out_flag", out_flag, 0);
        check("R1 pump_sel", pump_sel, 0);
        check("R1 misc", {ref_sel, lpf_sel, swallow_mode, am_band}, 0);
        check("R1 prog_ratio", prog_ratio, 0);
        check("R1 swallow_cnt", swallow_cnt, 0);
        check("R1 standby", standby, 1);
    endtask

    task automatic t_ctrl_word();
        send({2'b00, 6'b101_1_1_0}, 8);
        check("R3 test_bits", test_bits, 5);
        check("R10 out_flag high", out_flag, 1);
        check("R3 pump_sel[0]", pump_sel, 1);
        check("R3 ref_sel", ref_sel, 0);
        check("R2 msb first", standby, 1);
    endtask

    task automatic t_ctrlhi_word();
        send({2'b01, 6'b10_1_1_0_1}, 8);
        check("R4 lpf_sel", lpf_sel, 1);
        check("R4 pump_sel", pump_sel, 3);
        check("R4 swallow_mode", swallow_mode, 0);
        check("R4 am_band", am_band, 1);
        check("R6 ratio not yet", prog_ratio, 0);
    endtask

    task automatic t_ratlo_word();
        send({2'b10, 6'b110011}, 8);
        check("R5 ratio held", prog_ratio, 0);
        check("R5 others held", {test_bits, swallow_cnt}, {3'd5, 6'd0});
    endtask

    task automatic t_commit_latency();
        frame_open({2'b11, 6'b010101}, 8);
        ser_en = 1'b0;
        wait_neg(2);
        check("R11 old ratio after two edges", prog_ratio, 0);
        check("R11 old standby after two edges", standby, 1);
        @(negedge clk);
        check("R11 R6 ratio committed", prog_ratio, 8'b10110011);
        check("R6 swallow_cnt", swallow_cnt, 21);
        check("R9 standby cleared", standby, 0);
        wait_neg(4);
    endtask

    task automatic t_bad_length();
        send({2'b11, 6'b111111}, 7);
        check("R7 seven edges swallow", swallow_cnt, 21);
        check("R7 seven edges ratio", prog_ratio, 8'b10110011);
        send({2'b00, 6'b010_0_0_1}, 9);
        check("R7 nine edges test_bits", test_bits, 5);
        check("R7 nine edges flag", out_flag, 1);
    endtask

    task automatic t_idle_clock();
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            ser_data = 1'b1; ser_clk = 1'b1; wait_neg(4);
            ser_clk = 1'b0; wait_neg(4);
        end
        wait_neg(4);
        check("R2 idle clocks ignored", {test_bits, out_flag, swallow_cnt}, {3'd5, 1'b1, 6'd21});
        send({2'b00, 6'b011_0_0_1}, 8);
        check("R2 word after idle clocks", test_bits, 3);
        check("R10 out_flag low", out_flag, 0);
        check("R3 ref_sel set", ref_sel, 1);
    endtask

    task automatic t_order_repeat();
        send({2'b10, 6'b000111}, 8);
        send({2'b01, 6'b01_0_0_1_0}, 8);
        send({2'b01, 6'b11_0_0_1_0}, 8);
        check("R8 ratio waits", prog_ratio, 8'b10110011);
        check("R8 last ctrlhi wins", {lpf_sel, pump_sel[1], swallow_mode, am_band}, 4'b0010);
        send({2'b11, 6'b000010}, 8);
        check("R8 reordered ratio", prog_ratio, 8'b11000111);
        check("R8 swallow", swallow_cnt, 2);
        check("R9 standby stays low", standby, 0);
    endtask

    initial begin
        t_reset();
        t_ctrl_word();
        t_ctrlhi_word();
        t_ratlo_word();
        t_commit_latency();
        t_bad_length();
        t_idle_clock();
        t_order_repeat();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule